// File: doc/BRIEF.md
# Oscillator Alarm and Shutdown Manager

This block supervises a bank of free-running oscillator entropy lanes (32 by default). For each lane it holds four bits: an enable, a detune setting, an alarm mask and a stopped flag. An external health detector raises a one-cycle alarm pulse per lane. Each enabled, unmasked lane counts its alarms. When the count would pass a programmable threshold, the block switches that lane off and records it as stopped.

A global event counter tracks these shutdowns. The second shutdown, on any lane, produces a single-cycle overflow pulse, which is meant for a neighbouring status register. Software recovers a stopped lane in three steps: it rewrites the detune value, clears the mask and stopped registers, and writes ones back to the enable register.

All registers are reached over a simple 32-bit write/read port. Writes are registered, and read data is decoded combinationally from the address. The oscillators themselves sit outside this block.

Top module: `osc_alarm_mgr`

## Requirements
- R1: After reset, the enable, detune, mask and stopped registers read 0. The threshold reads 0x000000FF, and `shutdown_ovf` is 0.
- R2: The registers sit at these byte offsets: threshold at 0x1C (bits 7:0; bits 31:8 read 0), enable at 0x20, detune at 0x24, mask at 0x28 and stopped at 0x2C. Bit i of each lane register belongs to lane i. Any other offset reads 0, and a write to it has no effect. `lane_en` and `lane_detune` follow the enable and detune registers.
- R3: Each alarm pulse on an enabled, unmasked lane advances that lane's count. The pulse that arrives when the count already equals the threshold is a shutdown: the lane's enable bit clears and its stopped bit sets, one clock later. With threshold 0, the first pulse causes a shutdown. With threshold 0xFF, the 256th pulse does.
- R4: A lane whose mask bit is 1 ignores alarm pulses. Its count does not advance and it is never shut down.
- R5: Writing 1 to a lane's enable bit resets that lane's alarm count to zero.
- R6: The first shutdown event after reset or after a clear gives no overflow. The second gives `shutdown_ovf` high for exactly one cycle, in the same cycle the stopped bit appears. Shutdowns of two lanes in the same cycle count as two events. Later events give no further pulse until the next clear.
- R7: Writing all zeros to the stopped register clears the event count. The next shutdown is then again a first event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| alarm_pulse | input | 32 | Per-lane alarm pulses from the detector |
| lane_en | output | 32 | Per-lane oscillator enables |
| lane_detune | output | 32 | Per-lane detune settings |
| shutdown_ovf | output | 1 | One-cycle pulse on the second shutdown event |

## Verification
The bench builds the block with its defaults: 32 lanes, an 8-bit count and a reset threshold of 0xFF. The threshold is a register, so the bench lowers it to 2 and to 0 at run time. That makes shutdowns, masking and count resets quick to reach. The reset value of 0xFF is still driven to its full 256-pulse boundary. Using all 32 lanes lets two lanes trip in the same cycle, which covers the double-event case.

// File: rtl/osc_alarm_mgr.sv
module osc_alarm_mgr #(
  parameter int NUM_LANES = 32,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [CNT_W-1:0] THR_RESET = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_LANES-1:0] alarm_pulse,
  output logic [NUM_LANES-1:0] lane_en,
  output logic [NUM_LANES-1:0] lane_detune,
  output logic                 shutdown_ovf
);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(8'h2C);

  logic [NUM_LANES-1:0] en_q, det_q, mask_q, stop_q, trip;
  logic [CNT_W-1:0]     thr_q;
  logic [1:0]           evt_q, evt_base, trip_n, evt_next;
  logic [2:0]           evt_sum;
  logic                 ovf_q;

  wire wr_thr  = reg_wr && (reg_addr == A_THR);
  wire wr_en   = reg_wr && (reg_addr == A_EN);
  wire wr_det  = reg_wr && (reg_addr == A_DET);
  wire wr_mask = reg_wr && (reg_addr == A_MASK);
  wire wr_stop = reg_wr && (reg_addr == A_STOP);
  wire [NUM_LANES-1:0] wlanes = reg_wdata[NUM_LANES-1:0];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [CNT_W-1:0] cnt_q;
    wire hit = alarm_pulse[i] & en_q[i] & ~mask_q[i];
    assign trip[i] = hit && (cnt_q >= thr_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (wr_en && wlanes[i])     cnt_q <= '0;
      else if (hit && (cnt_q < thr_q)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign trip_n   = (|(trip & (trip - NUM_LANES'(1)))) ? 2'd2 : {1'b0, |trip};
  assign evt_base = (wr_stop && (wlanes == '0)) ? 2'd0 : evt_q;
  assign evt_sum  = {1'b0, evt_base} + {1'b0, trip_n};
  assign evt_next = (evt_sum >= 3'd2) ? 2'd2 : evt_sum[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      det_q  <= '0;
      mask_q <= '0;
      stop_q <= '0;
      thr_q  <= THR_RESET;
      evt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      en_q   <= (wr_en ? wlanes : en_q) & ~trip;
      stop_q <= (wr_stop ? wlanes : stop_q) | trip;
      if (wr_det)  det_q  <= wlanes;
      if (wr_mask) mask_q <= wlanes;
      if (wr_thr)  thr_q  <= reg_wdata[CNT_W-1:0];
      evt_q  <= evt_next;
      ovf_q  <= (evt_base < 2'd2) && (evt_sum >= 3'd2);
    end
  end

  always_comb begin
    case (reg_addr)
      A_THR:   reg_rdata = DATA_W'(thr_q);
      A_EN:    reg_rdata = DATA_W'(en_q);
      A_DET:   reg_rdata = DATA_W'(det_q);
      A_MASK:  reg_rdata = DATA_W'(mask_q);
      A_STOP:  reg_rdata = DATA_W'(stop_q);
      default: reg_rdata = '0;
    endcase
  end

  assign lane_en      = en_q;
  assign lane_detune  = det_q;
  assign shutdown_ovf = ovf_q;
endmodule

// File: rtl/osc_alarm_mgr_chk.sv
module osc_alarm_mgr_chk #(
  parameter int NUM_LANES = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [DATA_W-1:0]    reg_rdata,
  input logic [NUM_LANES-1:0] lane_en,
  input logic                 shutdown_ovf,
  input logic [NUM_LANES-1:0] stop_q,
  input logic [NUM_LANES-1:0] mask_q
);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(8'h2C);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (lane_en == '0 && !shutdown_ovf));

  p_thr_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_THR) |-> (reg_rdata[DATA_W-1:8] == '0));

  p_stop_disables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_STOP) |=> ((stop_q & ~$past(stop_q) & lane_en) == '0));

  p_masked_no_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_STOP) |=> ((stop_q & ~$past(stop_q) & $past(mask_q)) == '0));

  p_ovf_with_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_ovf |-> (stop_q != '0));
endmodule

bind osc_alarm_mgr osc_alarm_mgr_chk #(
  .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .lane_en(lane_en), .shutdown_ovf(shutdown_ovf),
  .stop_q(stop_q), .mask_q(mask_q)
);

// File: tb/osc_alarm_mgr_tb.sv
`timescale 1ns/1ps
module osc_alarm_mgr_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] alarm_pulse = 0;
  logic [31:0] lane_en, lane_detune;
  logic        shutdown_ovf;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  osc_alarm_mgr u_dut (.*);

  localparam logic [71:0] VEC [6] = '{
    {8'h1C, 32'hA5A5_A5F0, 32'h0000_00F0},
    {8'h20, 32'h1234_5678, 32'h1234_5678},
    {8'h24, 32'hCAFE_0F0F, 32'hCAFE_0F0F},
    {8'h28, 32'h8000_0001, 32'h8000_0001},
    {8'h2C, 32'h0000_0F00, 32'h0000_0F00},
    {8'h30, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); alarm_pulse = m;
      @(negedge clk); alarm_pulse = 0;
    end
  endtask

  task automatic setup(input logic [7:0] thr);
    wr(8'h2C, 0); wr(8'h28, 0); wr(8'h1C, {24'h0, thr}); wr(8'h20, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(8'h1C, v); check("R1 threshold", v, 32'hFF);
    rd(8'h20, v); check("R1 enable", v, 0);
    rd(8'h24, v); check("R1 detune", v, 0);
    rd(8'h28, v); check("R1 mask", v, 0);
    rd(8'h2C, v); check("R1 stopped", v, 0);
    check("R1 ovf", {31'h0, shutdown_ovf}, 0);
    @(negedge clk); rst_n = 1;

    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][71:64], VEC[k][63:32]);
      rd(VEC[k][71:64], v);
      check("R2 register row", v, VEC[k][31:0]);
    end
    check("R2 lane_en port", lane_en, 32'h1234_5678);
    check("R2 lane_detune port", lane_detune, 32'hCAFE_0F0F);

    setup(8'd2);
    pulse(32'h8, 2);
    check("R3 below threshold", lane_en, 32'hFFFF_FFFF);
    pulse(32'h8, 1);
    check("R3 trip enable", lane_en, 32'hFFFF_FFF7);
    rd(8'h2C, v); check("R3 trip stopped", v, 32'h8);
    check("R6 first event no ovf", {31'h0, shutdown_ovf}, 0);

    wr(8'h28, 32'h20);
    pulse(32'h20, 5);
    rd(8'h2C, v); check("R4 masked not stopped", v, 32'h8);
    check("R4 masked still enabled", lane_en, 32'hFFFF_FFF7);
    wr(8'h28, 0);
    pulse(32'h20, 2);
    check("R4 count did not advance", lane_en, 32'hFFFF_FFF7);
    pulse(32'h20, 1);
    check("R6 second event ovf", {31'h0, shutdown_ovf}, 1);
    @(negedge clk);
    check("R6 ovf one cycle", {31'h0, shutdown_ovf}, 0);
    rd(8'h2C, v); check("R3 stopped two lanes", v, 32'h28);

    wr(8'h2C, 0);
    wr(8'h20, 32'hFFFF_FFFF);
    pulse(32'h80, 2);
    wr(8'h20, 32'hFFFF_FFFF);
    pulse(32'h80, 2);
    check("R5 count reset by enable write", lane_en, 32'hFFFF_FFFF);
    pulse(32'h80, 1);
    check("R7 event after clear no ovf", {31'h0, shutdown_ovf}, 0);
    rd(8'h2C, v); check("R7 stopped lane 7", v, 32'h80);

    setup(8'd0);
    pulse(32'h600, 1);
    check("R6 simultaneous ovf", {31'h0, shutdown_ovf}, 1);
    rd(8'h2C, v); check("R3 threshold zero trip", v, 32'h600);
    pulse(32'h800, 1);
    check("R6 no repeat ovf", {31'h0, shutdown_ovf}, 0);
    check("R3 lane 11 stopped", lane_en, 32'hFFFF_F1FF);

    setup(8'hFF);
    pulse(32'h1, 255);
    check("R3 255 pulses enabled", lane_en, 32'hFFFF_FFFF);
    pulse(32'h1, 1);
    check("R3 256th pulse trips", lane_en, 32'hFFFF_FFFE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule